// File: doc/BRIEF.md
# Cluster-Aware Fast Inter-Processor Interrupt Fabric

This block lets any core of a multi-cluster processor raise a fast interrupt on any other core, or on itself. Cores are numbered flat as `cluster * CORES_PER_CLUSTER + core`. Each core owns a request port and chooses between two register views. The local view names only a core index and always lands in the sender's own cluster. The global view also carries a cluster number. Software uses the local view when sender and target share a cluster, and the global view otherwise.

Every request carries a two-bit kind: immediate, retract, deferred or no-wake. A deferred request arms a per-target timer loaded from the sender's countdown register, and it fires when that timer runs out. A retract disarms the timer. Each target keeps one pending flag, which drives its fast interrupt line as a level. The target clears the flag by writing 1 to bit 0 of its status register. A separate wake output pulses when a request is meant to bring the core out of a low-power state. No-wake requests leave that output low.

Top module: `fipi_fabric`

## Requirements
- R1: After reset every pending flag, every `fiq` bit and every `wake` bit is 0, and every countdown register holds 0.
- R2: A request word holds the target core index in bits [7:0], the target cluster in bits [23:16] and the kind in bits [29:28]. The kinds are 0 immediate, 1 retract, 2 deferred and 3 no-wake. The flat target number is cluster * CORES_PER_CLUSTER + core.
- R3: A request with `req_global` low targets the sender's own cluster, and bits [23:16] of the word are ignored.
- R4: A request with `req_global` high targets the cluster given in bits [23:16].
- R5: An immediate request sets the target's pending flag, which shows on `fiq` from the next cycle and stays high until cleared. In that same cycle `wake` of the target is high for exactly one cycle.
- R6: A deferred request sets pending D+1 cycles later than an immediate request issued in the same cycle would. D is the value in the sender's countdown register. That register is written through `cnt_wr`/`cnt_wdata` and applies to requests in later cycles. `wake` pulses when the timer fires.
- R7: A retract cancels a deferred request to the same target that has not fired yet. It has no effect on a pending flag that is already set.
- R8: A no-wake request sets pending (and `fiq`) exactly as an immediate request does, but the target's `wake` stays low.
- R9: A status write (`stat_wr`) with data bit 0 equal to 1 clears the target's pending flag from the next cycle. With data bit 0 equal to 0 it has no effect.
- R10: If a pending flag is set and cleared in the same cycle, it ends up set.
- R11: A request whose cluster or core index is beyond the configured counts is dropped, and no core sees any effect.
- R12: A deferred request to a target whose timer is already armed restarts the timer with the new countdown. When several deferred requests reach one target in the same cycle, the lowest-numbered sender's countdown is used. A retract in the same cycle as a deferred request or as a firing wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NCORE | Per-sender request strobe |
| req_global | input | NCORE | Per-sender view select: 1 global, 0 local |
| req_word | input | NCORE*32 | Per-sender request word, sender s at bits [32*s +: 32] |
| stat_wr | input | NCORE | Per-core status register write strobe |
| stat_wdata | input | NCORE | Per-core status write data bit 0 (1 clears pending) |
| cnt_wr | input | NCORE | Per-core countdown register write strobe |
| cnt_wdata | input | NCORE*CNT_W | Per-core countdown value, core s at bits [CNT_W*s +: CNT_W] |
| fiq | output | NCORE | Per-core fast interrupt level (pending flag) |
| wake | output | NCORE | Per-core one-cycle wake pulse |

## Verification
The bench builds the fabric with two clusters of three cores each and a 4-bit countdown. With three cores per cluster, core index 3 is out of range even though it fits in the index field, so the R11 drop check reaches a value that a power-of-two count would hide. Two clusters make the local and global views reach different targets for the same index. The narrow countdown keeps deferred windows short, so firing, restart, same-cycle arbitration and retract timing can each be checked cycle by cycle.

// File: rtl/fipi_pkg.sv
package fipi_pkg;

   localparam int WORD_W   = 32;
   localparam int CORE_LSB = 0;
   localparam int CORE_W   = 8;
   localparam int CLUS_LSB = 16;
   localparam int CLUS_W   = 8;
   localparam int KIND_LSB = 28;
   localparam int KIND_W   = 2;
   localparam int MAX_IDX  = 1 << CORE_W;

   typedef enum logic [KIND_W-1:0] {
      KIND_NOW    = 2'd0,
      KIND_CANCEL = 2'd1,
      KIND_LATER  = 2'd2,
      KIND_QUIET  = 2'd3
   } req_kind_e;

endpackage

// File: rtl/fipi_decode.sv
module fipi_decode
   import fipi_pkg::*;
#(
   parameter int NUM_CLUSTERS      = 4,
   parameter int CORES_PER_CLUSTER = 4,
   parameter int SELF_CLUSTER      = 0,
   localparam int NCORE            = NUM_CLUSTERS * CORES_PER_CLUSTER
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  logic              use_global,
   input  logic [WORD_W-1:0] word,
   output logic [NCORE-1:0]  hit,
   output req_kind_e         kind
);

   localparam logic [CLUS_W-1:0] SELF_CL = CLUS_W'(SELF_CLUSTER);

   logic [CLUS_W-1:0] cl_sel;
   logic [CORE_W-1:0] core_sel;
   logic              in_range;
   logic              unused_fields;

   assign unused_fields = ^{word[WORD_W-1:KIND_LSB+KIND_W],
                            word[KIND_LSB-1:CLUS_LSB+CLUS_W],
                            word[CLUS_LSB-1:CORE_LSB+CORE_W]};

   assign cl_sel   = use_global ? word[CLUS_LSB +: CLUS_W] : SELF_CL;
   assign core_sel = word[CORE_LSB +: CORE_W];
   assign in_range = valid && (int'(cl_sel) < NUM_CLUSTERS)
                           && (int'(core_sel) < CORES_PER_CLUSTER);
   assign kind     = req_kind_e'(word[KIND_LSB +: KIND_W]);

   always_comb begin
      hit = '0;
      for (int t = 0; t < NCORE; t++) begin
         if (in_range && (t == int'(cl_sel) * CORES_PER_CLUSTER + int'(core_sel)))
            hit[t] = 1'b1;
      end
   end

   // R2: one request reaches at most one target
   a_r2_single_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));

   // R11: a global request naming a missing cluster touches nobody
   a_r11_bad_cluster_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && use_global && int'(word[CLUS_LSB +: CLUS_W]) >= NUM_CLUSTERS) |-> (hit == '0));

   // R11: a core index past the cluster size touches nobody
   a_r11_bad_core_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && int'(word[CORE_LSB +: CORE_W]) >= CORES_PER_CLUSTER) |-> (hit == '0));

endmodule

// File: rtl/fipi_defer_timer.sv
module fipi_defer_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             cancel,
   output logic             fire
);

   logic             armed;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         cnt   <= '0;
      end else if (cancel) begin
         armed <= 1'b0;
      end else if (load) begin
         armed <= 1'b1;
         cnt   <= load_val;
      end else if (armed) begin
         if (cnt == '0)
            armed <= 1'b0;
         else
            cnt <= cnt - CNT_W'(1);
      end
   end

   assign fire = armed && (cnt == '0) && !cancel && !load;

   // R7: a retract leaves nothing to fire in the following cycle
   a_r7_cancel_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      cancel |=> !fire);

   // R12: a fresh deferred request restarts the timer with its own count
   a_r12_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !cancel) |=> (armed && cnt == $past(load_val)));

   // R6: an armed, undisturbed timer counts down by one each cycle
   a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && cnt != '0 && !cancel && !load) |=> (armed && cnt == $past(cnt) - CNT_W'(1)));

   // R6: firing retires the timer
   a_r6_fire_once: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !$past(load)) |=> !armed || $past(load));

endmodule

// File: rtl/fipi_pend_cell.sv
module fipi_pend_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_wake,
   input  logic set_quiet,
   input  logic clr,
   output logic pend,
   output logic wake
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
         wake <= 1'b0;
      end else begin
         wake <= set_wake;
         if (set_wake || set_quiet)
            pend <= 1'b1;
         else if (clr)
            pend <= 1'b0;
      end
   end

   // R10: a set in the same cycle as a clear still leaves pending high
   a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set_wake || set_quiet) |=> pend);

   // R9: a clear with no competing set drops pending
   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set_wake && !set_quiet) |=> !pend);

   // R9: without set or clear the flag holds
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !set_wake && !set_quiet) |=> $stable(pend));

   // R8: a quiet set alone never raises wake
   a_r8_quiet_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (set_quiet && !set_wake) |=> !wake);

   // R5: wake is a single-cycle pulse unless re-triggered
   a_r5_wake_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (wake && !set_wake) |=> !wake);

endmodule

// File: rtl/fipi_fabric.sv
module fipi_fabric
   import fipi_pkg::*;
#(
   parameter int NUM_CLUSTERS      = 4,
   parameter int CORES_PER_CLUSTER = 4,
   parameter int CNT_W             = 16,
   localparam int NCORE            = NUM_CLUSTERS * CORES_PER_CLUSTER
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NCORE-1:0]       req_valid,
   input  logic [NCORE-1:0]       req_global,
   input  logic [NCORE*WORD_W-1:0] req_word,
   input  logic [NCORE-1:0]       stat_wr,
   input  logic [NCORE-1:0]       stat_wdata,
   input  logic [NCORE-1:0]       cnt_wr,
   input  logic [NCORE*CNT_W-1:0] cnt_wdata,
   output logic [NCORE-1:0]       fiq,
   output logic [NCORE-1:0]       wake
);

   if (NUM_CLUSTERS < 1 || NUM_CLUSTERS > MAX_IDX) begin : g_bad_clusters
      $error("fipi_fabric: NUM_CLUSTERS out of range");
   end
   if (CORES_PER_CLUSTER < 1 || CORES_PER_CLUSTER > MAX_IDX) begin : g_bad_cores
      $error("fipi_fabric: CORES_PER_CLUSTER out of range");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("fipi_fabric: CNT_W must be positive");
   end

   logic [NCORE-1:0] hit   [NCORE];
   req_kind_e        kind  [NCORE];
   logic [CNT_W-1:0] cdown [NCORE];

   logic [NCORE-1:0] now_hit;
   logic [NCORE-1:0] quiet_hit;
   logic [NCORE-1:0] cancel_hit;
   logic [NCORE-1:0] later_hit;
   logic [CNT_W-1:0] later_val [NCORE];
   logic [NCORE-1:0] fired;
   logic [NCORE-1:0] pend;

   // per-sender decode and countdown register
   for (genvar s = 0; s < NCORE; s++) begin : g_sender
      fipi_decode #(
         .NUM_CLUSTERS      (NUM_CLUSTERS),
         .CORES_PER_CLUSTER (CORES_PER_CLUSTER),
         .SELF_CLUSTER      (s / CORES_PER_CLUSTER)
      ) u_dec (
         .clk        (clk),
         .rst_n      (rst_n),
         .valid      (req_valid[s]),
         .use_global (req_global[s]),
         .word       (req_word[s*WORD_W +: WORD_W]),
         .hit        (hit[s]),
         .kind       (kind[s])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cdown[s] <= '0;
         else if (cnt_wr[s])
            cdown[s] <= cnt_wdata[s*CNT_W +: CNT_W];
      end
   end

   // gather requests per target; scanning high to low lets the lowest sender win
   always_comb begin
      now_hit    = '0;
      quiet_hit  = '0;
      cancel_hit = '0;
      later_hit  = '0;
      for (int t = 0; t < NCORE; t++) begin
         later_val[t] = '0;
         for (int s = NCORE - 1; s >= 0; s--) begin
            if (hit[s][t]) begin
               unique case (kind[s])
                  KIND_NOW:    now_hit[t]    = 1'b1;
                  KIND_QUIET:  quiet_hit[t]  = 1'b1;
                  KIND_CANCEL: cancel_hit[t] = 1'b1;
                  KIND_LATER: begin
                     later_hit[t] = 1'b1;
                     later_val[t] = cdown[s];
                  end
               endcase
            end
         end
      end
   end

   // per-target deferred timer and pending flag
   for (genvar t = 0; t < NCORE; t++) begin : g_target
      fipi_defer_timer #(
         .CNT_W (CNT_W)
      ) u_timer (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (later_hit[t]),
         .load_val (later_val[t]),
         .cancel   (cancel_hit[t]),
         .fire     (fired[t])
      );

      fipi_pend_cell u_pend (
         .clk       (clk),
         .rst_n     (rst_n),
         .set_wake  (now_hit[t] || fired[t]),
         .set_quiet (quiet_hit[t]),
         .clr       (stat_wr[t] && stat_wdata[t]),
         .pend      (pend[t]),
         .wake      (wake[t])
      );
   end

   assign fiq = pend;

   // R5: an immediate request is seen on the target's line one cycle later
   a_r5_immediate_raises: assert property (@(posedge clk) disable iff (!rst_n)
      (now_hit != '0) |=> ((fiq & $past(now_hit)) == $past(now_hit)));

   // R7: a retract never lowers a flag that is already up
   a_r7_retract_keeps_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (cancel_hit != '0 && stat_wr == '0) |=> ((fiq & $past(fiq)) == $past(fiq)));

   // R5: wake only accompanies a newly or re-set pending flag
   a_r5_wake_implies_fiq: assert property (@(posedge clk) disable iff (!rst_n)
      ((wake & ~fiq) == '0));

endmodule

// File: tb/tb_fipi_fabric.sv
module tb_fipi_fabric;
   import fipi_pkg::*;

   localparam int NCL   = 2;
   localparam int CPC   = 3;
   localparam int CW    = 4;
   localparam int N     = NCL * CPC;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic [N-1:0]        req_valid;
   logic [N-1:0]        req_global;
   logic [N*WORD_W-1:0] req_word;
   logic [N-1:0]        stat_wr;
   logic [N-1:0]        stat_wdata;
   logic [N-1:0]        cnt_wr;
   logic [N*CW-1:0]     cnt_wdata;
   logic [N-1:0]        fiq;
   logic [N-1:0]        wake;

   fipi_fabric #(
      .NUM_CLUSTERS      (NCL),
      .CORES_PER_CLUSTER (CPC),
      .CNT_W             (CW)
   ) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_global (req_global),
      .req_word   (req_word),
      .stat_wr    (stat_wr),
      .stat_wdata (stat_wdata),
      .cnt_wr     (cnt_wr),
      .cnt_wdata  (cnt_wdata),
      .fiq        (fiq),
      .wake       (wake)
   );

   always #5 clk = ~clk;

   typedef struct {
      int           cyc;
      logic [N-1:0] fiq;
      logic [N-1:0] wake;
      string        tag;
   } exp_t;

   exp_t q[$];
   exp_t it;
   int   cyc = 0;
   int   checks = 0;
   int   errors = 0;
   bit   done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: pop every expectation due this cycle and compare
   always @(negedge clk) begin
      if (rst_n) begin
         while (q.size() > 0 && q[0].cyc <= cyc) begin
            it = q.pop_front();
            checks++;
            if (it.cyc != cyc || fiq !== it.fiq || wake !== it.wake) begin
               errors++;
               $display("FAIL %s cyc=%0d: fiq=%b wake=%b expected fiq=%b wake=%b (due %0d)",
                        it.tag, cyc, fiq, wake, it.fiq, it.wake, it.cyc);
            end
         end
      end
   end

   task automatic expect_at(input int k, input logic [N-1:0] f, input logic [N-1:0] w,
                            input string tag);
      exp_t e;
      e.cyc = cyc + k; e.fiq = f; e.wake = w; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic idle();
      req_valid = '0; req_global = '0; req_word = '0;
      stat_wr = '0; stat_wdata = '0; cnt_wr = '0; cnt_wdata = '0;
   endtask

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         idle();
      end
   endtask

   task automatic send(input int s, input bit glob, input int cl, input int co, input int kd);
      req_valid[s]  = 1'b1;
      req_global[s] = glob;
      req_word[s*WORD_W +: WORD_W] = (32'(kd) << KIND_LSB) | (32'(cl) << CLUS_LSB) | 32'(co);
   endtask

   task automatic clear(input logic [N-1:0] m);
      stat_wr = m; stat_wdata = m;
   endtask

   initial begin
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      expect_at(1, '0, '0, "R1 reset");
      tick();

      // R3, R5: local immediate, cluster field 1 ignored -> core 2
      send(0, 1'b0, 1, 2, 0);
      expect_at(1, 6'b000100, 6'b000100, "R5 immediate set");
      expect_at(2, 6'b000100, 6'b000000, "R5 level held, wake one cycle");
      tick(2);

      // R9: write with bit0=0 has no effect, then bit0=1 clears
      stat_wr[2] = 1'b1; stat_wdata[2] = 1'b0;
      expect_at(1, 6'b000100, 6'b000000, "R9 zero write ignored");
      tick();
      clear(6'b000100);
      expect_at(1, '0, '0, "R9 clear");
      tick();

      // R4 global to cluster1 core0 (=3); R3 local from core4, field 0 ignored -> 4
      send(1, 1'b1, 1, 0, 0);
      send(4, 1'b0, 0, 1, 0);
      expect_at(1, 6'b011000, 6'b011000, "R4 global and R3 local");
      tick();
      clear(6'b011000);
      expect_at(1, '0, '0, "R9 clear two");
      tick();

      // R11: missing cluster, core index 3 in 3-core cluster, huge index
      send(0, 1'b1, 2, 0, 0);
      send(1, 1'b0, 0, 3, 0);
      send(5, 1'b1, 0, 200, 0);
      expect_at(1, '0, '0, "R11 dropped");
      expect_at(2, '0, '0, "R11 dropped later");
      tick(2);

      // R8: no-wake to core 5
      send(0, 1'b1, 1, 2, 3);
      expect_at(1, 6'b100000, '0, "R8 no-wake set");
      expect_at(2, 6'b100000, '0, "R8 no-wake held");
      tick(2);
      clear(6'b100000);
      expect_at(1, '0, '0, "R9 clear");
      tick();

      // R6: core 1 countdown = 3, deferred to core 0
      cnt_wr[1] = 1'b1; cnt_wdata[1*CW +: CW] = 4'd3;
      expect_at(1, '0, '0, "R6 countdown write quiet");
      tick();
      send(1, 1'b0, 0, 0, 2);
      for (int k = 1; k <= 4; k++) expect_at(k, '0, '0, "R6 not yet");
      expect_at(5, 6'b000001, 6'b000001, "R6 fire after D+1");
      expect_at(6, 6'b000001, '0, "R6 held after fire");
      tick(6);

      // R7: retract leaves a set flag alone
      send(3, 1'b1, 0, 0, 1);
      expect_at(1, 6'b000001, '0, "R7 pending kept");
      tick();
      clear(6'b000001);
      expect_at(1, '0, '0, "R9 clear");
      tick();

      // R6: unwritten countdown of core 2 is 0
      send(2, 1'b0, 0, 1, 2);
      expect_at(1, '0, '0, "R6 zero countdown not yet");
      expect_at(2, 6'b000010, 6'b000010, "R6 zero countdown fire");
      tick(2);
      clear(6'b000010);
      expect_at(1, '0, '0, "R9 clear");
      tick();

      // R7: retract cancels armed deferred to core 4
      send(1, 1'b1, 1, 1, 2);
      for (int k = 1; k <= 7; k++) expect_at(k, '0, '0, "R7 retract cancels");
      tick(2);
      send(5, 1'b0, 0, 1, 1);
      tick(5);

      // R10: set and clear of core 1 in one cycle
      send(3, 1'b1, 0, 1, 0);
      clear(6'b000010);
      expect_at(1, 6'b000010, 6'b000010, "R10 set wins");
      tick();
      clear(6'b000010);
      expect_at(1, '0, '0, "R9 clear");
      tick();

      // R12: restart an armed timer with a shorter count
      send(1, 1'b0, 0, 2, 2);
      for (int k = 1; k <= 3; k++) expect_at(k, '0, '0, "R12 restart not yet");
      expect_at(4, 6'b000100, 6'b000100, "R12 restart fire");
      expect_at(5, 6'b000100, '0, "R12 no second fire");
      tick(2);
      send(2, 1'b0, 0, 2, 2);
      tick(3);
      clear(6'b000100);
      expect_at(1, '0, '0, "R9 clear");
      tick();

      // R12: two deferred senders in one cycle, lowest index (core 1, D=3) used
      send(1, 1'b1, 1, 2, 2);
      send(2, 1'b1, 1, 2, 2);
      for (int k = 1; k <= 4; k++) expect_at(k, '0, '0, "R12 lowest sender wait");
      expect_at(5, 6'b100000, 6'b100000, "R12 lowest sender fire");
      tick(5);
      clear(6'b100000);
      expect_at(1, '0, '0, "R9 clear");
      tick();

      // R12: retract and deferred in the same cycle -> nothing fires
      send(2, 1'b1, 1, 0, 2);
      send(4, 1'b0, 0, 0, 1);
      for (int k = 1; k <= 3; k++) expect_at(k, '0, '0, "R12 retract beats deferred");
      tick(3);

      tick(2);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule